// File: doc/BRIEF.md
# Nested-Select Carry-Select Adder

This block is a purely combinational 32-bit adder with carry-in and carry-out. The word is cut into four 8-bit slices. The bottom slice is an ordinary ripple adder that takes the external carry-in. Every slice above it holds two ripple adders working in parallel: one assumes an incoming carry of 0, the other an incoming carry of 1.

A multiplexer tree then picks each upper slice's result. It does not wait for a carry to ripple from slice to slice. It steps down through the conditional carry-outs of every lower slice's two chains, which turns a candidate pair for one slice into a candidate pair for the slice beneath it. Only the bottom slice's real carry-out drives the last multiplexer level. The overall carry-out is picked by the same tree, applied to the top slice's two conditional carry-outs.

The block is meant for a single-cycle datapath that needs a wide add with a shallow carry path. The surrounding logic registers the inputs and outputs.

Top module: `csel_adder`

## Requirements
- R1: `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^32 for every input combination.
- R2: `carry_out` equals bit 32 of the 33-bit value `op_a` + `op_b` + `carry_in`.
- R3: `sum_out[7:0]` equals the low 8 bits of `op_a[7:0]` + `op_b[7:0]` + `carry_in`, whatever the upper operand bits are.
- R4: Each upper slice of `sum_out` (bits [15:8], [23:16], [31:24]) equals one of its two precomputed candidates: the slice sum with carry-in 0, or the slice sum with carry-in 1.
- R5: A carry created in the lowest bit propagates through every slice boundary: 0xFFFFFFFF + 0x00000000 with `carry_in` = 1 gives `sum_out` = 0x00000000 and `carry_out` = 1.
- R6: A carry crosses exactly the boundaries it reaches: 0x00FFFFFF + 0x00000001 gives 0x01000000 with `carry_out` = 0, and 0x0000FFFF + 0x00000001 gives 0x00010000.
- R7: With both operands zero, `carry_in` alone sets the result: 0 + 0 + 1 gives 0x00000001 with `carry_out` = 0.
- R8: The largest sum, 0xFFFFFFFF + 0xFFFFFFFF + 1, gives `sum_out` = 0xFFFFFFFF and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Sum modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The assertions are immediate checks. They assume the inputs hold known 0/1 values whenever the combinational outputs are compared, and that the operands stay still long enough for the outputs to settle. The bench meets both assumptions: it drives every input from a task on the falling clock edge with no X or Z values, and it samples the outputs a full clock period later. The stimulus mixes fixed carry chains that end at each slice boundary with seeded random operands, so both candidates of every slice are selected.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int SLICE_W   = 8;
    localparam int SLICE_CNT = 4;
    localparam int WORD_W    = SLICE_W * SLICE_CNT;

    typedef logic [SLICE_W-1:0] slice_t;

    // Both speculative results of one upper slice.
    typedef struct packed {
        slice_t sum0;
        slice_t sum1;
        logic   co0;
        logic   co1;
    } cand_pair_t;

    function automatic logic bit_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

    function automatic logic bit_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x ^ y));
    endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]       = csel_pkg::bit_sum(a[i], b[i], chain[i]);
        assign chain[i+1] = csel_pkg::bit_carry(a[i], b[i], chain[i]);
    end

    assign co = chain[W];
endmodule

// File: rtl/csel_dual_slice.sv
module csel_dual_slice
    import csel_pkg::*;
(
    input  slice_t     a,
    input  slice_t     b,
    output cand_pair_t pair
);
    slice_t s_lo, s_hi;
    logic   c_lo, c_hi;

    csel_ripple #(.W(SLICE_W)) u_assume0 (
        .a(a), .b(b), .ci(1'b0), .s(s_lo), .co(c_lo)
    );

    csel_ripple #(.W(SLICE_W)) u_assume1 (
        .a(a), .b(b), .ci(1'b1), .s(s_hi), .co(c_hi)
    );

    assign pair = '{sum0: s_lo, sum1: s_hi, co0: c_lo, co1: c_hi};
endmodule

// File: rtl/csel_select_tree.sv
module csel_select_tree
    import csel_pkg::*;
(
    input  cand_pair_t [SLICE_CNT-1:1]   cands,
    input  logic                         base_carry,
    output logic [WORD_W-1:SLICE_W]      upper_sum,
    output logic                         carry_out
);
    // For slice k the candidate pair is indexed by the carry entering slice k.
    // Each step down through slice j re-indexes it by the carry entering slice j,
    // using slice j's two conditional carry-outs as mux selects.
    for (genvar k = 1; k < SLICE_CNT; k++) begin : g_slice
        slice_t picked;

        always_comb begin
            slice_t v0, v1, n0, n1;
            v0 = cands[k].sum0;
            v1 = cands[k].sum1;
            for (int j = k - 1; j >= 1; j--) begin
                n0 = cands[j].co0 ? v1 : v0;
                n1 = cands[j].co1 ? v1 : v0;
                v0 = n0;
                v1 = n1;
            end
            picked = base_carry ? v1 : v0;
        end

        assign upper_sum[k*SLICE_W +: SLICE_W] = picked;
    end

    // The carry-out goes through the same tree as the top slice's sum.
    always_comb begin
        logic w0, w1, m0, m1;
        w0 = cands[SLICE_CNT-1].co0;
        w1 = cands[SLICE_CNT-1].co1;
        for (int j = SLICE_CNT - 2; j >= 1; j--) begin
            m0 = cands[j].co0 ? w1 : w0;
            m1 = cands[j].co1 ? w1 : w0;
            w0 = m0;
            w1 = m1;
        end
        carry_out = base_carry ? w1 : w0;
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              carry_in,
    output logic [WORD_W-1:0] sum_out,
    output logic              carry_out
);
    cand_pair_t [SLICE_CNT-1:1] cands;
    logic                       low_carry;
    slice_t                     low_sum;

    csel_ripple #(.W(SLICE_W)) u_low (
        .a  (op_a[SLICE_W-1:0]),
        .b  (op_b[SLICE_W-1:0]),
        .ci (carry_in),
        .s  (low_sum),
        .co (low_carry)
    );

    for (genvar k = 1; k < SLICE_CNT; k++) begin : g_upper
        csel_dual_slice u_dual (
            .a    (op_a[k*SLICE_W +: SLICE_W]),
            .b    (op_b[k*SLICE_W +: SLICE_W]),
            .pair (cands[k])
        );
    end

    csel_select_tree u_tree (
        .cands      (cands),
        .base_carry (low_carry),
        .upper_sum  (sum_out[WORD_W-1:SLICE_W]),
        .carry_out  (carry_out)
    );

    assign sum_out[SLICE_W-1:0] = low_sum;
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk
    import csel_pkg::*;
(
    input logic [WORD_W-1:0]          op_a,
    input logic [WORD_W-1:0]          op_b,
    input logic                       carry_in,
    input logic [WORD_W-1:0]          sum_out,
    input logic                       carry_out,
    input cand_pair_t [SLICE_CNT-1:1] cands
);
    logic [WORD_W:0]  full_ref;
    logic [SLICE_W:0] low_ref;

    always_comb begin
        full_ref = {1'b0, op_a} + {1'b0, op_b} + {{WORD_W{1'b0}}, carry_in};
        low_ref  = {1'b0, op_a[SLICE_W-1:0]} + {1'b0, op_b[SLICE_W-1:0]}
                 + {{SLICE_W{1'b0}}, carry_in};

        assert_word_sum_R1: assert (sum_out == full_ref[WORD_W-1:0])
            else $error("R1 sum mismatch");
        assert_carry_out_R2: assert (carry_out == full_ref[WORD_W])
            else $error("R2 carry mismatch");
        assert_low_slice_R3: assert (sum_out[SLICE_W-1:0] == low_ref[SLICE_W-1:0])
            else $error("R3 low slice mismatch");

        for (int k = 1; k < SLICE_CNT; k++) begin
            assert_pick_candidate_R4: assert (
                (sum_out[k*SLICE_W +: SLICE_W] == cands[k].sum0) ||
                (sum_out[k*SLICE_W +: SLICE_W] == cands[k].sum1))
                else $error("R4 slice %0d not a candidate", k);
        end

        if ((op_a ^ op_b) == {WORD_W{1'b1}}) begin
            assert_full_propagate_R5: assert (carry_out == carry_in)
                else $error("R5 propagate chain broken");
        end
    end
endmodule

bind csel_adder csel_adder_chk u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .cands     (cands)
);

// File: tb/csel_adder_bench.sv
module csel_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csel_adder u_csel_adder (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_out(sum_out), .carry_out(carry_out)
    );

    task automatic apply_and_check(input string req, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input logic ci);
        logic [W:0] expv;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci;
        expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        @(negedge clk);
        checks++;
        if (sum_out !== expv[W-1:0] || carry_out !== expv[W]) begin
            errors++;
            $display("FAIL %s a=%h b=%h ci=%0d actual=%0d_%h expected=%0d_%h",
                     req, a, b, ci, carry_out, sum_out, expv[W], expv[W-1:0]);
        end
    endtask

    task automatic test_reset_state();  // R1 with idle zero inputs
        apply_and_check("R1", 32'h0, 32'h0, 1'b0);
    endtask

    task automatic test_full_ripple();
        apply_and_check("R5", 32'hFFFF_FFFF, 32'h0, 1'b1);
        apply_and_check("R5", 32'hFFFF_FFFF, 32'h1, 1'b0);
    endtask

    task automatic test_boundaries();
        apply_and_check("R6", 32'h00FF_FFFF, 32'h1, 1'b0);
        apply_and_check("R6", 32'h0000_FFFF, 32'h1, 1'b0);
        apply_and_check("R6", 32'h0000_00FF, 32'h1, 1'b0);
        apply_and_check("R6", 32'h00FF_0000, 32'h0001_0000, 1'b0);
    endtask

    task automatic test_cin_only();
        apply_and_check("R7", 32'h0, 32'h0, 1'b1);
    endtask

    task automatic test_max();
        apply_and_check("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        apply_and_check("R2", 32'h8000_0000, 32'h8000_0000, 1'b0);
    endtask

    task automatic test_low_slice_isolation();  // R3: upper bits vary, low slice fixed
        apply_and_check("R3", 32'h1234_56F0, 32'hABCD_EF0F, 1'b1);
        apply_and_check("R3", 32'h0000_00F0, 32'hFFFF_FF0F, 1'b1);
        @(negedge clk);
        checks++;
        if (sum_out[7:0] !== 8'h00) begin
            errors++;
            $display("FAIL R3 low slice actual=%h expected=00", sum_out[7:0]);
        end
    endtask

    task automatic test_alternating();  // R4: each slice takes either candidate
        apply_and_check("R4", 32'h80FF_00FF, 32'h8001_0001, 1'b0);
        apply_and_check("R4", 32'h7F00_FF00, 32'h0100_0100, 1'b1);
    endtask

    task automatic test_random();
        for (int i = 0; i < 200; i++) begin
            apply_and_check("R1", $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd77));
        test_reset_state();
        test_full_ripple();
        test_boundaries();
        test_cin_only();
        test_max();
        test_low_slice_isolation();
        test_alternating();
        test_random();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule